// File: doc/BRIEF.md
# Nibble Command Register Decoder

This block sits on the device side of a byte-wide command link and turns a stream of command bytes into accesses to a small register file. Each command byte holds an opcode in bits 7:4 and a 4-bit payload in bits 3:0. The host builds an 8-bit register address from two nibble commands. It builds an 8-bit write value from a low-nibble command and a high-nibble command, and the register is written when the high nibble arrives. A read command places one byte, the value of the addressed register, on an output byte stream. A second read opcode also steps the address on by one afterwards, so the host can fetch multi-byte values with a run of reads.

Address 0 holds a fixed identification value. Addresses 1 to NUM_REGS-1 are plain read/write registers. The host can use them as scratch locations to test the link by writing a pattern and reading it back. The contents of all registers are presented side by side on a flat output for the surrounding logic. Both streams use a valid/ready handshake. The decoder stops taking commands while a read result is waiting to be accepted.

Top module: `nibble_reg_decoder`

## Requirements
- R1: After reset, rsp_valid is 0, cmd_ready is 1, the address is 0x00, the held low data nibble is 0, and every read/write register holds 0x00.
- R2: Opcode 0x0 replaces address bits 3:0 with the payload. Opcode 0x1 replaces address bits 7:4 with the payload. Each of them leaves the other half of the address unchanged.
- R3: Opcode 0x2 only stores the payload as the pending low data nibble and changes no register. Opcode 0x3 writes {payload, pending low nibble} to the addressed register.
- R4: Any number of 0x2/0x3 pairs may follow one address, and every 0x3 writes to the same address, because writes never move the address. The pending low nibble is kept after a write, so a repeated 0x3 reuses it.
- R5: Opcode 0x4 returns exactly one byte, the value of the addressed register, on rsp_data, and leaves the address unchanged.
- R6: Opcode 0x5 returns the addressed register's value and then adds one to the address, wrapping from 0xFF to 0x00.
- R7: Address 0 always reads as ID_VALUE (default 0xA6), and writes to it have no effect.
- R8: Addresses 1 to NUM_REGS-1 read back the last value written to them. Addresses at or above NUM_REGS read as 0x00, and writes to them have no effect.
- R9: Opcodes 0x6 to 0xF are accepted and ignored: no response, no register change, no address change.
- R10: cmd_ready is 0 whenever rsp_valid is 1. While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data holds its value.
- R11: Byte i of regs_flat (bits 8i+7 to 8i) shows the current value of register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Decoder can take a command byte |
| cmd_data | input | 8 | Command byte: opcode in 7:4, payload in 3:0 |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_data | output | 8 | Read result byte |
| regs_flat | output | NUM_REGS*8 | All register values, register i in byte i |

## Verification
The bench targets the points where nibbles are combined. A decoder that wrote on the low-nibble command, or that cleared the held low nibble after a write, would produce the wrong byte in the repeated-pair test. A design that moved the address after a write would scatter those bytes across several registers. The auto-increment reads are run across three registers and across the 0xFF wrap; an increment done before the read, or one that saturated instead of wrapping, would shift or stick the returned bytes. Writes to the identification address and to unmapped addresses, the undefined opcodes, and a long stall on the response stream each check for the absence of a change, so a design that leaked any of these would alter regs_flat, emit a stray byte, or drop or change a held result.

// File: rtl/nibble_reg_decoder.sv
module nibble_reg_decoder #(
  parameter int NUM_REGS = 16,
  parameter logic [7:0] ID_VALUE = 8'hA6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [7:0]            cmd_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [7:0]            rsp_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam logic [3:0] OP_ADDR_LO = 4'h0;
  localparam logic [3:0] OP_ADDR_HI = 4'h1;
  localparam logic [3:0] OP_DATA_LO = 4'h2;
  localparam logic [3:0] OP_DATA_WR = 4'h3;
  localparam logic [3:0] OP_READ    = 4'h4;
  localparam logic [3:0] OP_READ_NX = 4'h5;

  logic [7:0] addr_q;
  logic [3:0] lo_q;
  logic [7:0] store_q [1:NUM_REGS-1];
  logic [7:0] rd_byte;

  wire       acc = cmd_valid && cmd_ready;
  wire [3:0] op  = cmd_data[7:4];
  wire [3:0] nib = cmd_data[3:0];
  wire       wr_en = acc && (op == OP_DATA_WR);
  wire       rd_en = acc && (op == OP_READ || op == OP_READ_NX);

  assign cmd_ready = !rsp_valid;

  always_comb begin
    rd_byte = 8'h00;
    if (addr_q == 8'h00) rd_byte = ID_VALUE;
    for (int i = 1; i < NUM_REGS; i++)
      if (addr_q == 8'(i)) rd_byte = store_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= 8'h00;
      lo_q   <= 4'h0;
    end else if (acc) begin
      case (op)
        OP_ADDR_LO: addr_q[3:0] <= nib;
        OP_ADDR_HI: addr_q[7:4] <= nib;
        OP_DATA_LO: lo_q        <= nib;
        OP_READ_NX: addr_q      <= addr_q + 8'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i < NUM_REGS; i++) store_q[i] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 1; i < NUM_REGS; i++)
        if (addr_q == 8'(i)) store_q[i] <= {nib, lo_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (rd_en) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    if (g == 0) begin : g_id
      assign regs_flat[7:0] = ID_VALUE;
    end else begin : g_rw
      assign regs_flat[g*8 +: 8] = store_q[g];
    end
  end
endmodule

// File: rtl/nibble_reg_decoder_chk.sv
module nibble_reg_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_data,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic [7:0] addr_q
);
  wire acc = cmd_valid && cmd_ready;

  assert_addr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[7:4] == 4'h0 |=> addr_q == {$past(addr_q[7:4]), $past(cmd_data[3:0])});

  assert_addr_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[7:4] == 4'h1 |=> addr_q == {$past(cmd_data[3:0]), $past(addr_q[3:0])});

  assert_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[7:4] == 4'h4 |=> rsp_valid && addr_q == $past(addr_q));

  assert_read_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[7:4] == 4'h5 |=> rsp_valid && addr_q == $past(addr_q) + 8'd1);

  assert_ignored_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[7:4] > 4'h5 |=> !rsp_valid && $stable(addr_q));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

bind nibble_reg_decoder nibble_reg_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .addr_q(addr_q)
);

// File: tb/nibble_reg_decoder_test.sv
module nibble_reg_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [7:0]   cmd_data = 8'h00;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [7:0]   rsp_data;
  logic [127:0] regs_flat;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nibble_reg_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] nib);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = {op, nib};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send(4'h0, a[3:0]);
    send(4'h1, a[7:4]);
  endtask

  task automatic wr(input logic [7:0] b);
    send(4'h2, b[3:0]);
    send(4'h3, b[7:4]);
  endtask

  task automatic rd(input logic [3:0] op, output logic [7:0] b);
    send(op, 4'h0);
    while (!rsp_valid) @(negedge clk);
    b = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    chk("R1 rsp_valid", 128'(rsp_valid), 128'd0);
    chk("R1 cmd_ready", 128'(cmd_ready), 128'd1);
    chk("R1 regs_flat", regs_flat, 128'hA6);
    rd(4'h4, b);
    chk("R1 address zero reads id", 128'(b), 128'hA6);
  endtask

  task automatic t_scratch;
    logic [7:0] b;
    set_addr(8'h01);
    wr(8'h55);
    rd(4'h4, b);
    chk("R8 scratch 55", 128'(b), 128'h55);
    wr(8'hAA);
    rd(4'h4, b);
    chk("R8 scratch AA", 128'(b), 128'hAA);
    chk("R11 byte1 of regs_flat", 128'(regs_flat[15:8]), 128'hAA);
  endtask

  task automatic t_addr;
    logic [7:0] b;
    set_addr(8'h0F);
    wr(8'h3C);
    send(4'h0, 4'h2);
    wr(8'h12);
    chk("R2 low half only selects reg2", 128'(regs_flat[23:16]), 128'h12);
    send(4'h1, 4'h0);
    send(4'h0, 4'hF);
    rd(4'h4, b);
    chk("R2 reg15 readback", 128'(b), 128'h3C);
    send(4'h1, 4'h2);
    rd(4'h4, b);
    chk("R2 high half only gives 0x2F unmapped", 128'(b), 128'h00);
    send(4'h1, 4'h0);
    rd(4'h4, b);
    chk("R2 back to 0x0F", 128'(b), 128'h3C);
  endtask

  task automatic t_pairs;
    logic [7:0] b;
    set_addr(8'h03);
    wr(8'h21);
    chk("R4 first pair", 128'(regs_flat[31:24]), 128'h21);
    send(4'h3, 4'h4);
    chk("R4 low nibble kept", 128'(regs_flat[31:24]), 128'h41);
    wr(8'h77);
    rd(4'h4, b);
    chk("R4 same address", 128'(b), 128'h77);
    chk("R4 reg4 untouched", 128'(regs_flat[39:32]), 128'h00);
  endtask

  task automatic t_lowonly;
    logic [7:0] b;
    set_addr(8'h03);
    send(4'h2, 4'h9);
    rd(4'h4, b);
    chk("R3 low nibble alone no write", 128'(b), 128'h77);
    send(4'h3, 4'h0);
    rd(4'h4, b);
    chk("R3 commit on high nibble", 128'(b), 128'h09);
  endtask

  task automatic t_id;
    logic [7:0] b;
    set_addr(8'h00);
    wr(8'h12);
    rd(4'h4, b);
    chk("R7 id unchanged after write", 128'(b), 128'hA6);
  endtask

  task automatic t_range;
    logic [7:0]   b;
    logic [127:0] snap;
    snap = regs_flat;
    set_addr(8'h20);
    wr(8'hEE);
    chk("R8 unmapped write no effect", regs_flat, snap);
    rd(4'h4, b);
    chk("R8 unmapped reads zero", 128'(b), 128'h00);
  endtask

  task automatic t_incr;
    logic [7:0] b;
    set_addr(8'h05); wr(8'h11);
    set_addr(8'h06); wr(8'h22);
    set_addr(8'h07); wr(8'h33);
    set_addr(8'h05);
    rd(4'h5, b); chk("R6 first", 128'(b), 128'h11);
    rd(4'h5, b); chk("R6 second", 128'(b), 128'h22);
    rd(4'h5, b); chk("R6 third", 128'(b), 128'h33);
    rd(4'h4, b); chk("R5 address now 8", 128'(b), 128'h00);
    rd(4'h4, b); chk("R5 read does not advance", 128'(b), 128'h00);
    set_addr(8'hFF);
    rd(4'h5, b); chk("R6 at 0xFF", 128'(b), 128'h00);
    rd(4'h4, b); chk("R6 wrapped to 0", 128'(b), 128'hA6);
  endtask

  task automatic t_ignore;
    logic [7:0]   b;
    logic [127:0] snap;
    set_addr(8'h01);
    snap = regs_flat;
    for (int op = 6; op < 16; op++) begin
      send(4'(op), 4'(op));
      chk("R9 no response", 128'(rsp_valid), 128'd0);
      chk("R9 no register change", regs_flat, snap);
    end
    rd(4'h4, b);
    chk("R9 address unchanged", 128'(b), 128'hAA);
  endtask

  task automatic t_stall;
    logic [7:0] held;
    set_addr(8'h01);
    send(4'h4, 4'h0);
    held = rsp_data;
    chk("R10 result", 128'(held), 128'hAA);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 valid held", 128'(rsp_valid), 128'd1);
      chk("R10 not ready", 128'(cmd_ready), 128'd0);
      chk("R10 data stable", 128'(rsp_data), 128'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 released", 128'(rsp_valid), 128'd0);
    chk("R10 ready again", 128'(cmd_ready), 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_scratch;
    t_addr;
    t_pairs;
    t_lowonly;
    t_id;
    t_range;
    t_incr;
    t_ignore;
    t_stall;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule